// File: doc/BRIEF.md
# Overcurrent Retry Sequencer

This block decides when the enable of an external hot-swap power switch may be on. It takes the digital outputs of three fault comparators (overcurrent, undervoltage and overvoltage). It holds the gate enable low whenever any of them is active. After an overcurrent trip it waits a selectable interval, timed by a one-millisecond tick, and then turns the switch back on.

A 3-bit retry mode sets what repeated trips lead to. The options are endless silent retries, a fixed budget of one to five retries that ends in a locked-off state, endless retries that raise a warning once a retry has been used, and an immediate lock-off on the first trip. Each retry start adds to a retry count, and a successful run does not reset it. When the budget runs out, a sticky failure bit drives the failure output. An active-low overcurrent flag marks a trip that has not yet been retried or cleared. A one-cycle register-write strobe clears the failure bit, the flag and the count.

Top module: `ocp_retry_seq`

## Requirements
- R1: While rst_n is low, gate_en and fail_out are 0 and oc_flag_n is 1. On the first clock edge after reset is released with no fault input active, the block starts running and gate_en is 1.
- R2: gate_en is 1 only in the running state. It drops in the same cycle that oc_trip, uv_flt or ov_flt goes high.
- R3: oc_trip high in the running state causes a trip. From the next edge oc_flag_n is 0, the gate stays off and the retry wait starts. delay_sel is captured at the trip.
- R4: delay_sel 2'b00, 2'b01, 2'b10 and 2'b11 give waits of DLY_SEL0, DLY_SEL1, DLY_SEL2 and DLY_SEL3 ticks (defaults 100, 500, 1000, 5000). Only cycles with tick_ms high count. The retry starts on the edge that takes in the last tick. Changing delay_sel during a wait has no effect on that wait.
- R5: At a retry start oc_flag_n returns to 1 and gate_en returns to 1 if no fault is present. The retry count goes up by one and saturates at its maximum. The count is not reset by a fault-free run.
- R6: retry_mode 3'b000 retries without limit and never raises fail_out.
- R7: retry_mode 3'b001 to 3'b101 allow N = 1 to 5 retries. A trip that arrives after N retries have been made sets fail_out, stops retrying and holds gate_en low until wr_clr.
- R8: retry_mode 3'b110 retries without limit. A trip after at least one retry sets fail_out. fail_out returns to 0 when oc_flag_n returns to 1 at the next retry start or at a write.
- R9: retry_mode 3'b111 sets fail_out and locks the gate off on the first trip, with no retry.
- R10: A wr_clr pulse sets fail_out to 0, oc_flag_n to 1 and the retry count to 0 on the next edge. From the locked state it moves to idle, and gate_en returns one edge later if no fault is present. During a wait, the wait continues.
- R11: uv_flt or ov_flt in the running state moves the block to idle. This changes neither the retry count, oc_flag_n nor fail_out.
- R12: If a trip and wr_clr fall on the same edge, the trip is judged against the count held before the write. fail_out, oc_flag_n and the next state follow the trip, and the count is still zeroed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle millisecond time-base pulse |
| oc_trip | input | 1 | Overcurrent comparator output, active high |
| uv_flt | input | 1 | Undervoltage comparator output, active high |
| ov_flt | input | 1 | Overvoltage comparator output, active high |
| retry_mode | input | 3 | Retry policy code |
| delay_sel | input | 2 | Retry wait select |
| wr_clr | input | 1 | Register-write clear strobe |
| gate_en | output | 1 | Enable for the external switch gate |
| fail_out | output | 1 | Retry failure output (sticky failure bit) |
| oc_flag_n | output | 1 | Overcurrent flag, 0 after a trip |

## Verification
An overcurrent trip and a register-write clear can land on the same edge. In that case the block must decide at once whether the failure bit is set or cleared, and whether the count survives. The bench first builds up a retry count under the silent mode. It then switches to a one-retry budget and drives oc_trip and wr_clr in the same cycle. It judges the result by fail_out high, oc_flag_n low and the gate held off until a second write. A later trip under the same one-retry budget must then start a normal wait, which shows that the count was zeroed.

// File: rtl/ocp_retry_pkg.sv
package ocp_retry_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WAIT = 2'd2,
        ST_LOCK = 2'd3
    } seq_state_e;

    localparam int MODE_W = 3;
    localparam int DSEL_W = 2;

    localparam logic [MODE_W-1:0] RMODE_SILENT    = 3'b000;
    localparam logic [MODE_W-1:0] RMODE_FLAG_KEEP = 3'b110;
    localparam logic [MODE_W-1:0] RMODE_NO_RETRY  = 3'b111;

endpackage

// File: rtl/ocp_retry_policy.sv
module ocp_retry_policy
    import ocp_retry_pkg::*;
#(
    parameter int RC_W = 3
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [RC_W-1:0]   rc,
    output logic              trip_lock,
    output logic              trip_fail
);

    logic [RC_W-1:0] budget;

    assign budget = RC_W'(mode);

    always_comb begin
        trip_lock = 1'b0;
        trip_fail = 1'b0;
        case (mode)
            RMODE_SILENT: begin
                trip_lock = 1'b0;
                trip_fail = 1'b0;
            end
            RMODE_FLAG_KEEP: begin
                trip_lock = 1'b0;
                trip_fail = (rc != '0);
            end
            RMODE_NO_RETRY: begin
                trip_lock = 1'b1;
                trip_fail = 1'b1;
            end
            default: begin
                trip_lock = (rc >= budget);
                trip_fail = (rc >= budget);
            end
        endcase
    end

endmodule

// File: rtl/ocp_delay_table.sv
module ocp_delay_table #(
    parameter int unsigned D0    = 100,
    parameter int unsigned D1    = 500,
    parameter int unsigned D2    = 1000,
    parameter int unsigned D3    = 5000,
    parameter int          CNT_W = 13
) (
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] tgt
);

    localparam logic [CNT_W-1:0] TBL [4] = '{CNT_W'(D0), CNT_W'(D1), CNT_W'(D2), CNT_W'(D3)};

    assign tgt = TBL[sel];

endmodule

// File: rtl/ocp_delay_timer.sv
module ocp_delay_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] tgt,
    output logic             done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign done = run && tick && (cnt_q == (tgt - ONE));

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (run && tick) begin
            cnt_d = done ? '0 : cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/ocp_retry_seq.sv
module ocp_retry_seq
    import ocp_retry_pkg::*;
#(
    parameter int unsigned DLY_SEL0 = 100,
    parameter int unsigned DLY_SEL1 = 500,
    parameter int unsigned DLY_SEL2 = 1000,
    parameter int unsigned DLY_SEL3 = 5000,
    parameter int          RC_W     = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_ms,
    input  logic        oc_trip,
    input  logic        uv_flt,
    input  logic        ov_flt,
    input  logic [2:0]  retry_mode,
    input  logic [1:0]  delay_sel,
    input  logic        wr_clr,
    output logic        gate_en,
    output logic        fail_out,
    output logic        oc_flag_n
);

    localparam int unsigned MAX_01  = (DLY_SEL0 > DLY_SEL1) ? DLY_SEL0 : DLY_SEL1;
    localparam int unsigned MAX_23  = (DLY_SEL2 > DLY_SEL3) ? DLY_SEL2 : DLY_SEL3;
    localparam int unsigned DLY_MAX = (MAX_01 > MAX_23) ? MAX_01 : MAX_23;
    localparam int          CNT_W   = $clog2(DLY_MAX + 1);
    localparam logic [RC_W-1:0] RC_ONE = RC_W'(1);

    typedef struct packed {
        seq_state_e       state;
        logic [RC_W-1:0]  rc;
        logic             fail;
        logic             flag_n;
        logic [CNT_W-1:0] tgt;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             trip_lock, trip_fail;
    logic             tmr_restart, tmr_run, tmr_done;
    logic [CNT_W-1:0] sel_tgt;
    logic             any_flt, trip_now;
    seq_state_e       state_q;
    logic [RC_W-1:0]  rc_q;

    assign state_q = r_q.state;
    assign rc_q    = r_q.rc;

    ocp_retry_policy #(.RC_W(RC_W)) u_policy (
        .mode      (retry_mode),
        .rc        (r_q.rc),
        .trip_lock (trip_lock),
        .trip_fail (trip_fail)
    );

    ocp_delay_table #(
        .D0    (DLY_SEL0),
        .D1    (DLY_SEL1),
        .D2    (DLY_SEL2),
        .D3    (DLY_SEL3),
        .CNT_W (CNT_W)
    ) u_dtab (
        .sel (delay_sel),
        .tgt (sel_tgt)
    );

    ocp_delay_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .run     (tmr_run),
        .tick    (tick_ms),
        .tgt     (r_q.tgt),
        .done    (tmr_done)
    );

    assign any_flt  = oc_trip || uv_flt || ov_flt;
    assign trip_now = (r_q.state == ST_RUN) && oc_trip;
    assign tmr_run  = (r_q.state == ST_WAIT);

    always_comb begin
        r_d         = r_q;
        tmr_restart = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (!any_flt) begin
                    r_d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                if (oc_trip) begin
                    r_d.flag_n  = 1'b0;
                    r_d.tgt     = sel_tgt;
                    tmr_restart = 1'b1;
                    r_d.state   = trip_lock ? ST_LOCK : ST_WAIT;
                    if (trip_fail) begin
                        r_d.fail = 1'b1;
                    end
                end else if (uv_flt || ov_flt) begin
                    r_d.state = ST_IDLE;
                end
            end
            ST_WAIT: begin
                if (tmr_done) begin
                    r_d.state  = ST_RUN;
                    r_d.flag_n = 1'b1;
                    r_d.fail   = 1'b0;
                    if (r_q.rc != '1) begin
                        r_d.rc = r_q.rc + RC_ONE;
                    end
                end
            end
            ST_LOCK: begin
                if (wr_clr) begin
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        if (wr_clr) begin
            r_d.rc = '0;
            if (!trip_now) begin
                r_d.fail   = 1'b0;
                r_d.flag_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.rc     <= '0;
            r_q.fail   <= 1'b0;
            r_q.flag_n <= 1'b1;
            r_q.tgt    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign gate_en   = (r_q.state == ST_RUN) && !any_flt;
    assign fail_out  = r_q.fail;
    assign oc_flag_n = r_q.flag_n;

endmodule

// File: rtl/ocp_retry_seq_chk.sv
module ocp_retry_seq_chk
    import ocp_retry_pkg::*;
#(
    parameter int RC_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            oc_trip,
    input logic            uv_flt,
    input logic            ov_flt,
    input logic [2:0]      retry_mode,
    input logic            wr_clr,
    input logic            gate_en,
    input logic            fail_out,
    input logic            oc_flag_n,
    input seq_state_e      state_q,
    input logic [RC_W-1:0] rc_q
);

    AST_FLAG_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !oc_flag_n |-> !gate_en); // R3

    AST_TRIP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && oc_trip) |=> !oc_flag_n); // R3

    AST_FAIL_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        fail_out |-> !gate_en); // R7

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && !wr_clr) |=> (state_q == ST_LOCK)); // R7

    AST_SILENT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_mode == 3'b000 && state_q == ST_RUN && oc_trip) |=> !fail_out); // R6

    AST_NO_RETRY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_mode == 3'b111 && state_q == ST_RUN && oc_trip) |=> (fail_out && state_q == ST_LOCK)); // R9

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !(state_q == ST_RUN && oc_trip)) |=> (!fail_out && oc_flag_n)); // R10

    AST_CLEAR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> (rc_q == '0)); // R12

    AST_UVOV_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !oc_trip && (uv_flt || ov_flt) && !wr_clr) |=> $stable(rc_q)); // R11

endmodule

bind ocp_retry_seq ocp_retry_seq_chk #(.RC_W(RC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .oc_trip    (oc_trip),
    .uv_flt     (uv_flt),
    .ov_flt     (ov_flt),
    .retry_mode (retry_mode),
    .wr_clr     (wr_clr),
    .gate_en    (gate_en),
    .fail_out   (fail_out),
    .oc_flag_n  (oc_flag_n),
    .state_q    (state_q),
    .rc_q       (rc_q)
);

// File: tb/ocp_retry_seq_tb_top.sv
module ocp_retry_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       oc_trip = 1'b0;
    logic       uv_flt = 1'b0;
    logic       ov_flt = 1'b0;
    logic [2:0] retry_mode = 3'b000;
    logic [1:0] delay_sel = 2'b00;
    logic       wr_clr = 1'b0;
    logic       gate_en, fail_out, oc_flag_n;

    int n_chk = 0;
    int n_err = 0;
    bit done_f = 1'b0;

    always #2 clk = ~clk;

    ocp_retry_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_ms    (tick_ms),
        .oc_trip    (oc_trip),
        .uv_flt     (uv_flt),
        .ov_flt     (ov_flt),
        .retry_mode (retry_mode),
        .delay_sel  (delay_sel),
        .wr_clr     (wr_clr),
        .gate_en    (gate_en),
        .fail_out   (fail_out),
        .oc_flag_n  (oc_flag_n)
    );

    // columns: mode, delay_sel, expected ticks, trips, trip that raises fail (0 = none), ends locked
    localparam int NV = 8;
    localparam int VEC [NV][6] = '{
        '{0, 0,  100, 3, 0, 0},
        '{1, 1,  500, 2, 2, 1},
        '{3, 0,  100, 4, 4, 1},
        '{5, 0,  100, 6, 6, 1},
        '{6, 2, 1000, 3, 2, 0},
        '{7, 3, 5000, 1, 1, 1},
        '{2, 3, 5000, 3, 3, 1},
        '{4, 0,  100, 5, 5, 1}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_pulse();
        wr_clr = 1'b1;
        @(negedge clk);
        wr_clr = 1'b0;
    endtask

    task automatic trip_pulse();
        oc_trip = 1'b1;
        @(negedge clk);
        oc_trip = 1'b0;
        #1;
    endtask

    task automatic wait_flag(output int n);
        n = 0;
        while (oc_flag_n == 1'b0 && n < 6000) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic string mtag(input int m);
        case (m)
            0:       return "R6";
            6:       return "R8";
            7:       return "R9";
            default: return "R7";
        endcase
    endfunction

    initial begin
        int n;
        cyc(3);
        #1;
        chk("R1", "gate_en in reset", gate_en, 0);
        chk("R1", "fail_out in reset", fail_out, 0);
        chk("R1", "oc_flag_n in reset", oc_flag_n, 1);
        @(negedge clk);
        rst_n = 1'b1;
        tick_ms = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", "gate_en after release", gate_en, 1);

        // table walk over retry modes and delay codes
        for (int e = 0; e < NV; e++) begin
            retry_mode = 3'(VEC[e][0]);
            delay_sel  = 2'(VEC[e][1]);
            clear_pulse();
            cyc(1);
            #1;
            chk("R2", "gate_en before trips", gate_en, 1);
            for (int k = 1; k <= VEC[e][3]; k++) begin
                trip_pulse();
                chk("R3", "oc_flag_n after trip", oc_flag_n, 0);
                chk("R2", "gate_en after trip", gate_en, 0);
                chk(mtag(VEC[e][0]), "fail_out at trip",
                    fail_out, (VEC[e][4] != 0 && k >= VEC[e][4]) ? 1 : 0);
                if (VEC[e][5] == 1 && k == VEC[e][3]) begin
                    cyc(20);
                    #1;
                    chk(mtag(VEC[e][0]), "gate_en while locked", gate_en, 0);
                    chk(mtag(VEC[e][0]), "fail_out while locked", fail_out, 1);
                    clear_pulse();
                    #1;
                    chk("R10", "fail_out after clear", fail_out, 0);
                    chk("R10", "oc_flag_n after clear", oc_flag_n, 1);
                    @(negedge clk);
                    #1;
                    chk("R10", "gate_en after unlock", gate_en, 1);
                end else begin
                    wait_flag(n);
                    chk("R4", "wait length in ticks", n, VEC[e][2]);
                    #1;
                    chk("R5", "gate_en at retry", gate_en, 1);
                    chk("R8", "fail_out after retry", fail_out, 0);
                end
            end
        end

        // R11: undervoltage and overvoltage do not count as trips
        retry_mode = 3'b001;
        delay_sel  = 2'b00;
        clear_pulse();
        cyc(1);
        uv_flt = 1'b1;
        #1;
        chk("R2", "gate_en drops with uv_flt", gate_en, 0);
        @(negedge clk);
        #1;
        chk("R11", "oc_flag_n under uv_flt", oc_flag_n, 1);
        chk("R11", "fail_out under uv_flt", fail_out, 0);
        uv_flt = 1'b0;
        ov_flt = 1'b1;
        @(negedge clk);
        #1;
        chk("R2", "gate_en under ov_flt", gate_en, 0);
        ov_flt = 1'b0;
        @(negedge clk);
        #1;
        chk("R11", "gate_en after faults clear", gate_en, 1);
        trip_pulse();
        chk("R11", "fail_out on first trip after uv/ov", fail_out, 0);
        wait_flag(n);
        chk("R11", "wait length after uv/ov", n, 100);

        // R4: only ticks count, delay_sel captured at trip
        retry_mode = 3'b000;
        delay_sel  = 2'b00;
        clear_pulse();
        cyc(1);
        #1;
        tick_ms = 1'b0;
        trip_pulse();
        delay_sel = 2'b11;
        cyc(300);
        #1;
        chk("R4", "oc_flag_n with no ticks", oc_flag_n, 0);
        for (int i = 0; i < 99; i++) begin
            tick_ms = 1'b1;
            @(negedge clk);
            tick_ms = 1'b0;
            @(negedge clk);
        end
        #1;
        chk("R4", "oc_flag_n after 99 ticks", oc_flag_n, 0);
        tick_ms = 1'b1;
        @(negedge clk);
        tick_ms = 1'b0;
        #1;
        chk("R4", "oc_flag_n after 100th tick", oc_flag_n, 1);
        tick_ms = 1'b1;
        delay_sel = 2'b00;
        cyc(1);

        // R10: clear during a wait
        trip_pulse();
        cyc(10);
        clear_pulse();
        #1;
        chk("R10", "oc_flag_n after clear in wait", oc_flag_n, 1);
        chk("R10", "gate_en after clear in wait", gate_en, 0);
        cyc(100);
        #1;
        chk("R10", "gate_en after wait completes", gate_en, 1);

        // R12: trip and clear on the same edge
        trip_pulse();
        wait_flag(n);
        #1;
        retry_mode = 3'b001;
        oc_trip = 1'b1;
        wr_clr  = 1'b1;
        @(negedge clk);
        oc_trip = 1'b0;
        wr_clr  = 1'b0;
        #1;
        chk("R12", "fail_out trip with clear", fail_out, 1);
        chk("R12", "oc_flag_n trip with clear", oc_flag_n, 0);
        cyc(5);
        #1;
        chk("R12", "gate_en held locked", gate_en, 0);
        clear_pulse();
        @(negedge clk);
        #1;
        chk("R12", "gate_en after second clear", gate_en, 1);
        trip_pulse();
        chk("R12", "fail_out shows count zeroed", fail_out, 0);
        wait_flag(n);

        done_f = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done_f) begin
            n_chk++;
            n_err++;
            $display("FAIL WDOG watchdog expired: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule